// File: doc/BRIEF.md
# Quadrature Event Counter with Boundary Compare

This block counts motion events from a rotary encoder or a similar two-phase source. Two count inputs form a quadrature pair and are decoded at four counts per full cycle, which gives one signed step for every legal edge. A third input has two uses, chosen by a mode bit. It can act as a zero marker that clears the count. It can also act as a push-button that only raises a sticky status bit. Each of the three inputs is first synchronised and then passes through a debounce filter. The filter length is programmable, and a length of zero bypasses the filter.

The count is a 32-bit signed value that wraps on overflow. Two boundary registers are compared against it. The upper compare is strict greater-than and the lower compare is strict less-than. In interrupt mode, a crossing sets a sticky flag. In auto-zero mode, a crossing clears the count on the next clock and sets no flag. Every applied step also produces a one-cycle event pulse, which an external interval timer can use to measure the time between steps. Software reaches all state through a small single-cycle write port and a combinational read port.

Top module: `quad_event_counter`

## Requirements
- R1: After reset, COUNT (address 1) and STAT (address 4) read 0, `irq` is 0, UPPER (address 2) reads 32'h7FFFFFFF and LOWER (address 3) reads 32'h80000000.
- R2: The filtered pair {A,B} follows the Gray order 00→01→11→10→00. Each forward transition adds 1 to COUNT and each reverse transition subtracts 1.
- R3: When A and B both change in the same filtered sample, COUNT stays unchanged and STAT bit 2 is set.
- R4: CTRL bits [3:0] hold N. For N from 1 to 15, an input level is accepted only after N consecutive equal synchronised samples, so a pulse of N-1 cycles is ignored and a pulse of N cycles is taken. N=0 bypasses the filter.
- R5: `cnt_evt` is high for exactly one cycle for each step that is applied to COUNT.
- R6: With CTRL bit 4 clear, a filtered rising edge on the auxiliary input clears COUNT.
- R7: With CTRL bit 4 set, a filtered rising edge on the auxiliary input sets STAT bit 3 and leaves COUNT unchanged.
- R8: With CTRL bit 5 clear, signed COUNT > UPPER sets STAT bit 0 and signed COUNT < LOWER sets STAT bit 1. Equality sets neither.
- R9: With CTRL bit 5 set, a crossing of either boundary loads COUNT with 0 on the next clock and sets neither STAT bit 0 nor STAT bit 1.
- R10: STAT bits are sticky and are cleared by writing 1 to them at address 4. Bits written with 0 keep their value.
- R11: `irq` is the OR of STAT[k] AND CTRL[8+k], for k from 0 to 3.
- R12: A forward step from 32'h7FFFFFFF wraps COUNT to 32'h80000000.
- R13: A write to address 1 loads COUNT with the written data. This write takes priority over any step, marker or auto-zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_a | input | 1 | Quadrature phase A |
| in_b | input | 1 | Quadrature phase B |
| in_aux | input | 1 | Zero marker or push-button input |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address: 0 CTRL, 1 COUNT, 2 UPPER, 3 LOWER, 4 STAT |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| cnt_evt | output | 1 | One-cycle pulse for each applied step |

## Verification
The hardest situations to reach from the ports are the exact edges of the debounce window and a boundary crossing in auto-zero mode. The filter has to see a pulse exactly one cycle too short and then exactly long enough. The auto-zero case only shows up as a value of COUNT that appears for a single cycle. The bench drives pulses of exactly N-1 and N cycles at the falling edge and counts `cnt_evt` pulses, so it can observe an accept-then-revert even though COUNT ends where it started. Crossings are reached by loading COUNT next to a boundary through the write port and then taking a single quadrature step. Random legal and illegal moves, drawn from a fixed seed, are checked against a bench model of position and error state.

// File: rtl/quad_event_counter.sv
module quad_event_counter #(
  parameter int CW = 32,
  parameter int AW = 3,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_a,
  input  logic          in_b,
  input  logic          in_aux,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq,
  output logic          cnt_evt
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_COUNT = AW'(1);
  localparam logic [AW-1:0] A_UPPER = AW'(2);
  localparam logic [AW-1:0] A_LOWER = AW'(3);
  localparam logic [AW-1:0] A_STAT  = AW'(4);
  localparam int NF = 4;

  logic [DW-1:0]        dblen;
  logic                 auxbtn, autoz;
  logic [NF-1:0]        irq_en, flags_q;
  logic signed [CW-1:0] count_q, upper_q, lower_q;
  logic [2:0]           s1, s2, filt_q, filt, prev_q;
  logic                 evt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {in_aux, in_b, in_a};
      s2 <= s1;
    end

  for (genvar i = 0; i < 3; i++) begin : g_filt
    logic [DW-1:0] run;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run <= '0;
        filt_q[i] <= 1'b0;
      end else if (dblen == '0 || s2[i] == filt_q[i]) begin
        run <= '0;
        filt_q[i] <= s2[i];
      end else if ({1'b0, run} + 1'b1 >= {1'b0, dblen}) begin
        run <= '0;
        filt_q[i] <= s2[i];
      end else begin
        run <= run + 1'b1;
      end
    assign filt[i] = (dblen == '0) ? s2[i] : filt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= filt;

  logic [1:0] ph_new, ph_old, ph_d;
  assign ph_new = {filt[0], filt[0] ^ filt[1]};
  assign ph_old = {prev_q[0], prev_q[0] ^ prev_q[1]};
  assign ph_d   = ph_new - ph_old;

  logic step_up, step_dn, q_illegal, aux_rise, marker, over, under, az, wr_cnt, hold_ovr, step_ok;
  assign step_up   = (ph_d == 2'd1);
  assign step_dn   = (ph_d == 2'd3);
  assign q_illegal = (ph_d == 2'd2);
  assign aux_rise  = filt[2] & ~prev_q[2];
  assign marker    = aux_rise & ~auxbtn;
  assign over      = count_q > upper_q;
  assign under     = count_q < lower_q;
  assign az        = autoz & (over | under);
  assign wr_cnt    = reg_wr && reg_addr == A_COUNT;
  assign hold_ovr  = wr_cnt | marker | az;
  assign step_ok   = (step_up | step_dn) & ~hold_ovr;

  logic [NF-1:0] f_set, f_clr;
  assign f_set = {aux_rise & auxbtn, q_illegal, under & ~autoz, over & ~autoz};
  assign f_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NF-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_q <= '0;
      upper_q <= {1'b0, {(CW-1){1'b1}}};
      lower_q <= {1'b1, {(CW-1){1'b0}}};
      dblen   <= '0;
      auxbtn  <= 1'b0;
      autoz   <= 1'b0;
      irq_en  <= '0;
      flags_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q   <= step_ok;
      flags_q <= (flags_q & ~f_clr) | f_set;
      if (wr_cnt)                count_q <= reg_wdata;
      else if (marker || az)     count_q <= '0;
      else if (step_ok)          count_q <= step_up ? count_q + 1 : count_q - 1;
      if (reg_wr && reg_addr == A_UPPER) upper_q <= reg_wdata;
      if (reg_wr && reg_addr == A_LOWER) lower_q <= reg_wdata;
      if (reg_wr && reg_addr == A_CTRL) begin
        dblen  <= reg_wdata[DW-1:0];
        auxbtn <= reg_wdata[DW];
        autoz  <= reg_wdata[DW+1];
        irq_en <= reg_wdata[8 +: NF];
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[DW-1:0] = dblen;
        reg_rdata[DW]     = auxbtn;
        reg_rdata[DW+1]   = autoz;
        reg_rdata[8 +: NF] = irq_en;
      end
      A_COUNT: reg_rdata = count_q;
      A_UPPER: reg_rdata = upper_q;
      A_LOWER: reg_rdata = lower_q;
      A_STAT:  reg_rdata[NF-1:0] = flags_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = |(flags_q & irq_en);
  assign cnt_evt = evt_q;
endmodule

module qec_chk #(
  parameter int CW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_evt,
  input logic          irq,
  input logic [CW-1:0] count_q,
  input logic [3:0]    flags_q,
  input logic          q_illegal,
  input logic          hold_ovr,
  input logic          autoz,
  input logic          over,
  input logic          under,
  input logic          wr_cnt,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [CW-1:0] reg_wdata
);
  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt |-> ((count_q - $past(count_q)) == CW'(1) || (count_q - $past(count_q)) == {CW{1'b1}})); // R5
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_illegal && !hold_ovr) |=> $stable(count_q)); // R3
  AST_AUTOZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (autoz && (over || under) && !wr_cnt) |=> (count_q == '0)); // R9
  AST_AUTOZ_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (autoz && !flags_q[0]) |=> !flags_q[0]); // R9
  AST_STICKY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[0]) |-> $past(reg_wr && reg_addr == AW'(4) && reg_wdata[0])); // R10
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flags_q != '0)); // R11
endmodule

bind quad_event_counter qec_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_evt(cnt_evt), .irq(irq), .count_q(count_q),
  .flags_q(flags_q), .q_illegal(q_illegal), .hold_ovr(hold_ovr), .autoz(autoz),
  .over(over), .under(under), .wr_cnt(wr_cnt), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata));

// File: tb/quad_event_counter_tb.sv
module quad_event_counter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0, in_aux = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, cnt_evt;

  always #10 clk = ~clk;

  quad_event_counter dut_i (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_aux(in_aux),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .cnt_evt(cnt_evt));

  int vectors = 0, fails = 0, evt_seen = 0, evt_long = 0, exp_evt = 0;
  logic evt_prev = 1'b0;
  logic [1:0] ph = 2'd0;
  logic signed [31:0] exp_cnt = 0;
  logic exp_err = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (cnt_evt) evt_seen++;
    if (cnt_evt && evt_prev) evt_long++;
    evt_prev <= cnt_evt;
  end

  function automatic logic [1:0] ab_of(input logic [1:0] p);
    return {p[1] ^ p[0], p[1]};
  endfunction

  function automatic logic signed [31:0] step_val(input logic signed [31:0] c, input int d);
    return c + d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ph(input logic [1:0] p, input int settle);
    logic [1:0] ab;
    ab = ab_of(p);
    @(negedge clk);
    in_b = ab[1]; in_a = ab[0];
    repeat (settle) @(negedge clk);
  endtask

  task automatic move(input int d);
    ph = ph + 2'(d);
    set_ph(ph, 8);
    exp_cnt = step_val(exp_cnt, d);
    exp_evt++;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd1, v); check("R1 count", v, 32'd0);
    rd(3'd4, v); check("R1 stat", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd2, v); check("R1 upper", v, 32'h7FFF_FFFF);
    rd(3'd3, v); check("R1 lower", v, 32'h8000_0000);

    // R2 R3 R5: random legal and illegal moves
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 3) move(1);
      else if (r < 6) move(-1);
      else if (r == 6) begin
        ph = ph + 2'd2;
        set_ph(ph, 8);
        exp_err = 1'b1;
      end else repeat (3) @(negedge clk);
      if (i % 30 == 29) begin
        rd(3'd1, v); check("R2 random count", v, exp_cnt);
      end
    end
    ph = ph + 2'd2; set_ph(ph, 8); exp_err = 1'b1;
    rd(3'd1, v); check("R3 count held on illegal", v, exp_cnt);
    rd(3'd4, v); check("R3 err flag", v & 32'h4, exp_err ? 32'h4 : 32'h0);
    check("R5 pulse count", evt_seen, exp_evt);
    check("R5 pulse width", evt_long, 0);

    // R13
    wr(3'd1, 32'd100); exp_cnt = 100;
    rd(3'd1, v); check("R13 count load", v, 32'd100);

    // R4 debounce, N=8
    wr(3'd0, 32'd8);
    begin
      logic [1:0] np, ab;
      int base;
      np = ph + 2'd1; ab = ab_of(np);
      base = evt_seen;
      @(negedge clk); in_b = ab[1]; in_a = ab[0];
      repeat (7) @(negedge clk);
      ab = ab_of(ph); in_b = ab[1]; in_a = ab[0];
      repeat (30) @(negedge clk);
      check("R4 7-cycle pulse ignored", evt_seen - base, 0);
      ab = ab_of(np);
      in_b = ab[1]; in_a = ab[0];
      repeat (8) @(negedge clk);
      ab = ab_of(ph); in_b = ab[1]; in_a = ab[0];
      repeat (30) @(negedge clk);
      check("R4 8-cycle pulse taken", evt_seen - base, 2);
      exp_evt += 2;
      rd(3'd1, v); check("R4 count after pulse", v, exp_cnt);
      ph = ph + 2'd1; set_ph(ph, 30); exp_cnt++; exp_evt++;
      rd(3'd1, v); check("R4 filtered step", v, exp_cnt);
    end
    wr(3'd0, 32'd0);

    // R6 marker
    wr(3'd1, 32'd55);
    @(negedge clk); in_aux = 1'b1; repeat (5) @(negedge clk); in_aux = 1'b0; repeat (5) @(negedge clk);
    rd(3'd1, v); check("R6 marker clears", v, 32'd0);

    // R7 push-button, R10 partial clear
    wr(3'd0, 32'h10);
    wr(3'd1, 32'd55);
    @(negedge clk); in_aux = 1'b1; repeat (5) @(negedge clk); in_aux = 1'b0; repeat (5) @(negedge clk);
    rd(3'd1, v); check("R7 count untouched", v, 32'd55);
    rd(3'd4, v); check("R7 button flag", v & 32'h8, 32'h8);
    wr(3'd4, 32'h8);
    rd(3'd4, v); check("R10 w1c keeps others", v, exp_err ? 32'h4 : 32'h0);
    wr(3'd4, 32'hF);
    rd(3'd4, v); check("R10 all cleared", v, 32'd0);

    // R8 R11 interrupt mode
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'hFFFF_FFFD);
    wr(3'd0, 32'h100);
    wr(3'd1, 32'd3); exp_cnt = 3;
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R8 equal not over", v, 32'd0);
    move(1);
    rd(3'd4, v); check("R8 upper flag", v, 32'h1);
    check("R11 irq on enabled", {31'd0, irq}, 32'd1);
    move(-1); move(-1);
    rd(3'd4, v); check("R10 sticky", v, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R10 cleared", v, 32'd0);
    check("R11 irq dropped", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'hFFFF_FFFD); exp_cnt = -3;
    move(-1);
    rd(3'd4, v); check("R8 lower flag", v, 32'h2);
    check("R11 lower disabled", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h200);
    @(negedge clk);
    check("R11 lower enabled", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'd0); exp_cnt = 0;
    wr(3'd4, 32'hF);

    // R9 auto-zero
    wr(3'd0, 32'h320);
    wr(3'd1, 32'd3); exp_cnt = 3;
    move(1); exp_cnt = 0;
    rd(3'd1, v); check("R9 upper autozero", v, 32'd0);
    wr(3'd1, 32'hFFFF_FFFD); exp_cnt = -3;
    move(-1); exp_cnt = 0;
    rd(3'd1, v); check("R9 lower autozero", v, 32'd0);
    rd(3'd4, v); check("R9 no flags", v, 32'd0);
    check("R9 no irq", {31'd0, irq}, 32'd0);

    // R12 wrap
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h7FFF_FFFF);
    wr(3'd3, 32'h8000_0000);
    wr(3'd1, 32'h7FFF_FFFF); exp_cnt = 32'h7FFF_FFFF;
    move(1);
    rd(3'd1, v); check("R12 wrap", v, 32'h8000_0000);
    rd(3'd4, v); check("R12 no flags", v, 32'd0);
    check("R5 final pulses", evt_seen, exp_evt);

    finish_run();
  end
endmodule